// File: doc/BRIEF.md
# Eight-Pin Memory-Mapped GPIO Controller

This block gives software control of eight general-purpose pins through a simple 32-bit register bus with a 4 KB address window. Each pin can be an output that drives a stored data bit or an input whose level is sampled into that data bit. The lower quarter of the window is a data aperture in which address bits [9:2] form a per-bit mask, so software can read or change selected pins without a read-modify-write sequence.

Input pins pass through a two-stage synchronizer and feed an interrupt detector. Each pin can be set to detect a level (high or low) or an edge (rising, falling, or both). Detected events latch into a raw status register, which software clears by writing ones. A per-pin enable produces the masked status, and the single interrupt request is the OR of the masked bits.

The alternate-function select register is protected. Only bits set in a commit register can change, and the commit register itself can be written only after a 32-bit unlock key has been written to the lock register. Nine plain 8-bit storage registers hold pad settings, a fixed identification area can be read back, and undefined offsets read as zero and discard writes.

Top module: `gpio8_ctrl`

## Requirements
- R1: A read at an offset below 0x400 returns the data register ANDed with the mask held in address bits [9:2]. Bits [31:8] read as zero.
- R2: A write at an offset below 0x400 changes only the data bits that are set both in address bits [9:2] and in the direction register. Every other data bit keeps its value.
- R3: The direction register is at 0x400. It is 8 bits wide, resets to 0, and stores pwdata[7:0]. A 1 bit makes the pin an output.
- R4: Each bit of pin_out equals the data bit when the pin is an output, and equals 1 when the pin is an input.
- R5: For an input pin, the data bit follows pin_in through a two-flop synchronizer. The new level is visible three clock edges after pin_in changes. For an output pin, pin_in has no effect on the data bit.
- R6: A pin with sense (0x404) bit = 1 is in level mode. The polarity bit (0x40C) chooses a high level (1) or a low level (0). While the level holds, the raw status bit is set again even immediately after a clear.
- R7: A pin with sense bit = 0 is in edge mode. Both-edges (0x408) = 1 fires on any change. Otherwise polarity = 1 fires on a rising edge and polarity = 0 on a falling edge. Only input pins can set raw status.
- R8: Raw status reads at 0x414. Masked status at 0x418 equals raw AND the enable register (0x410). irq is the OR of the masked bits. Writing 1s to 0x41C clears those raw bits.
- R9: The lock register is at 0x520. Writing 0x0ACCE551 unlocks the block and writing any other value locks it. A read returns 1 when locked and 0 when unlocked. Reset leaves the block locked.
- R10: The commit register is at 0x524. It resets to 0xFF and accepts writes only while the block is unlocked.
- R11: A write to the alternate-function register (0x420) changes only the bits whose commit bit is 1.
- R12: Offsets 0x500 to 0x51C (step 4) and 0x528 are plain 8-bit read/write storage registers.
- R13: Offsets 0xFD0 to 0xFFC read one identification byte per word, in order: 00, 00, 00, 00, 61, 10, 04, 00, 0D, F0, 05, B1.
- R14: Reads of undefined offsets return 0, including 0x41C, which is write-only. Writes to undefined offsets, to the read-only status registers and to the identification area change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select; a write takes effect on the clock edge while psel and pwrite are high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr; zero when psel is low |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Driven pin levels |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench writes through narrow address masks while some pins are inputs. A design that ignored the direction gate or the mask would corrupt unrelated bits, and this shows up in pin_out and in the full-mask readback. It steps pins through rising, falling and both-edge changes, in each case with the other edge kind present but not selected. A detector with swapped polarity, or one that fires on the wrong edge, would leave stray raw bits. In level mode it clears while the level still holds: a design that lost the level would read zero instead of the re-set bit. It writes the commit register while locked, relocks with a wrong key, and writes alternate-function bits outside the commit mask. A leaky guard would let those values through. Finally it writes the read-only status and identification offsets and an unmapped offset, then reads them back to catch stores that should not happen.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
    localparam int PIN_W  = 8;
    localparam int ADDR_W = 12;
    localparam int BUS_W  = 32;
    localparam int PAD_N  = 9;
    localparam int ID_N   = 12;

    typedef logic [PIN_W-1:0]  pins_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t OFF_DIR    = 12'h400;
    localparam addr_t OFF_SENSE  = 12'h404;
    localparam addr_t OFF_BOTH   = 12'h408;
    localparam addr_t OFF_POL    = 12'h40C;
    localparam addr_t OFF_ENA    = 12'h410;
    localparam addr_t OFF_RAW    = 12'h414;
    localparam addr_t OFF_MIS    = 12'h418;
    localparam addr_t OFF_CLR    = 12'h41C;
    localparam addr_t OFF_ALT    = 12'h420;
    localparam addr_t OFF_PADB   = 12'h500;
    localparam addr_t OFF_ANA    = 12'h528;
    localparam addr_t OFF_LOCK   = 12'h520;
    localparam addr_t OFF_COMMIT = 12'h524;
    localparam addr_t OFF_IDB    = 12'hFD0;

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    // Interrupt configuration bundle, one bit per pin in each field.
    typedef struct packed {
        pins_t sense;
        pins_t both;
        pins_t polarity;
        pins_t enable;
    } irq_cfg_t;

    function automatic addr_t pad_addr(input int k);
        return (k < PAD_N - 1) ? addr_t'(OFF_PADB + addr_t'(4 * k)) : OFF_ANA;
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd4:    return 8'h61;
            4'd5:    return 8'h10;
            4'd6:    return 8'h04;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio8_irq_unit.sv
module gpio8_irq_unit
    import gpio8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pins_t    lvl,
    input  pins_t    dir,
    input  irq_cfg_t cfg,
    input  logic     clr_we,
    input  pins_t    clr_bits,
    output pins_t    raw
);
    pins_t prev_q, raw_q, rise, fall, lvl_hit, edge_hit, evt, clr_eff;

    assign rise     = lvl & ~prev_q;
    assign fall     = ~lvl & prev_q;
    assign lvl_hit  = ~(lvl ^ cfg.polarity);
    assign edge_hit = (cfg.both & (rise | fall))
                    | (~cfg.both & cfg.polarity & rise)
                    | (~cfg.both & ~cfg.polarity & fall);
    assign evt      = ~dir & ((cfg.sense & lvl_hit) | (~cfg.sense & edge_hit));
    assign clr_eff  = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            raw_q  <= '0;
        end else begin
            prev_q <= lvl;
            raw_q  <= (raw_q & ~clr_eff) | evt;
        end
    end

    assign raw = raw_q;

    // R7: a newly set status bit belongs to a pin that was an input
    a_r7_inputs_only: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & ~$past(raw_q) & $past(dir)) == '0));

    // R8: cleared bits stay clear unless an event arrived in the same cycle
    a_r8_clear_takes: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((raw_q & $past(clr_bits) & ~$past(evt)) == '0));
endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
    import gpio8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic              irq
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = MASK_LO + PIN_W - 1;

    pins_t    data_q, dir_q, alt_q, commit_q, raw, sync_lvl, wmask, wen_bits, wbyte;
    irq_cfg_t cfg_q;
    logic     locked_q;
    pins_t    pad_q [PAD_N];

    logic wr, data_win;
    assign wr       = psel & pwrite;
    assign data_win = (paddr[ADDR_W-1:MASK_HI+1] == '0);
    assign wmask    = paddr[MASK_HI:MASK_LO];
    assign wbyte    = pwdata[PIN_W-1:0];
    assign wen_bits = (wr && data_win) ? (wmask & dir_q) : '0;

    gpio8_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(pin_in), .q(sync_lvl)
    );

    gpio8_irq_unit irq_i (
        .clk(clk), .rst(rst), .lvl(sync_lvl), .dir(dir_q), .cfg(cfg_q),
        .clr_we(wr && paddr == OFF_CLR), .clr_bits(wbyte), .raw(raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_q    <= '0;
            alt_q    <= '0;
            commit_q <= '1;
            locked_q <= 1'b1;
        end else begin
            data_q <= ((((data_q & ~wen_bits) | (wbyte & wen_bits)) & dir_q)
                      | (sync_lvl & ~dir_q));
            if (wr) begin
                case (paddr)
                    OFF_DIR:    dir_q          <= wbyte;
                    OFF_SENSE:  cfg_q.sense    <= wbyte;
                    OFF_BOTH:   cfg_q.both     <= wbyte;
                    OFF_POL:    cfg_q.polarity <= wbyte;
                    OFF_ENA:    cfg_q.enable   <= wbyte;
                    OFF_ALT:    alt_q          <= (alt_q & ~commit_q) | (wbyte & commit_q);
                    OFF_LOCK:   locked_q       <= (pwdata != UNLOCK_KEY);
                    OFF_COMMIT: if (!locked_q) commit_q <= wbyte;
                    default: ;
                endcase
            end
        end
    end

    for (genvar k = 0; k < PAD_N; k++) begin : g_pad
        always_ff @(posedge clk) begin
            if (rst)                             pad_q[k] <= '0;
            else if (wr && paddr == pad_addr(k)) pad_q[k] <= wbyte;
        end
    end

    logic [3:0] id_idx;
    pins_t      rd_byte;
    logic [ADDR_W-1:0] id_off;
    assign id_off = paddr - OFF_IDB;
    assign id_idx = id_off[5:2];

    always_comb begin
        rd_byte = '0;
        if (data_win) begin
            rd_byte = data_q & wmask;
        end else if (paddr >= OFF_IDB) begin
            rd_byte = id_byte(id_idx);
        end else begin
            case (paddr)
                OFF_DIR:    rd_byte = dir_q;
                OFF_SENSE:  rd_byte = cfg_q.sense;
                OFF_BOTH:   rd_byte = cfg_q.both;
                OFF_POL:    rd_byte = cfg_q.polarity;
                OFF_ENA:    rd_byte = cfg_q.enable;
                OFF_RAW:    rd_byte = raw;
                OFF_MIS:    rd_byte = raw & cfg_q.enable;
                OFF_ALT:    rd_byte = alt_q;
                OFF_LOCK:   rd_byte = pins_t'(locked_q);
                OFF_COMMIT: rd_byte = commit_q;
                default: ;
            endcase
            for (int k = 0; k < PAD_N; k++)
                if (paddr == pad_addr(k)) rd_byte = pad_q[k];
        end
    end

    assign prdata  = psel ? {{(BUS_W-PIN_W){1'b0}}, rd_byte} : '0;
    assign pin_out = (data_q & dir_q) | ~dir_q;
    assign irq     = |(raw & cfg_q.enable);

    // R2: output bits outside the address mask keep their value on a data write
    a_r2_mask_guard: assert property (@(posedge clk) disable iff (rst)
        (wr && data_win) |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wmask)) == '0));

    // R9: the key unlocks
    a_r9_key_unlocks: assert property (@(posedge clk) disable iff (rst)
        (wr && paddr == OFF_LOCK && pwdata == UNLOCK_KEY) |=> !locked_q);

    // R10: commit is frozen while locked
    a_r10_commit_locked: assert property (@(posedge clk) disable iff (rst)
        (wr && paddr == OFF_COMMIT && locked_q) |=> $stable(commit_q));

    // R11: only committed bits of the alternate-function register move
    a_r11_alt_guard: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == '0));
endmodule

// File: tb/gpio8_ctrl_tb_top.sv
module gpio8_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio8_ctrl dut_i (
        .clk(clk), .rst(rst), .psel(psel), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    typedef struct {
        int          kind;   // 0 = prdata, 1 = pin_out, 2 = irq
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q_exp[$];
    event  sample_ev;

    // Monitor: pops one expected item per sample strobe and compares.
    initial begin
        forever begin
            @(sample_ev);
            while (q_exp.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q_exp.pop_front();
                act = (it.kind == 0) ? prdata :
                      (it.kind == 1) ? {24'h0, pin_out} : {31'h0, irq};
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 0; pwrite = 0;
    endtask

    task automatic push_sample(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        q_exp.push_back(it);
        #(CLK_P/4);
        ->sample_ev;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a;
        push_sample(0, e, tag);
        @(negedge clk);
        psel = 0;
    endtask

    task automatic pin_chk(input logic [7:0] e, input string tag);
        @(negedge clk);
        push_sample(1, {24'h0, e}, tag);
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(negedge clk);
        push_sample(2, {31'h0, e}, tag);
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] id_tab [12];
        id_tab = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10, 8'h04, 8'h00,
                   8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) @(negedge clk);
        rst = 0;

        // Reset state
        rd_chk(12'h400, 32'h00, "R3 dir reset");
        pin_chk(8'hFF, "R4 inputs drive high after reset");
        rd_chk(12'h520, 32'h1, "R9 locked after reset");
        rd_chk(12'h524, 32'hFF, "R10 commit reset");
        irq_chk(1'b0, "R8 irq low after reset");

        // Direction register width
        wr(12'h400, 32'h0000_01F0);
        rd_chk(12'h400, 32'hF0, "R3 only low byte stored");
        wr(12'h400, 32'h0F);
        rd_chk(12'h400, 32'h0F, "R3 dir write");

        // Data writes through mask and direction
        wr(12'h3FC, 32'hA5);
        pin_chk(8'hF5, "R4 outputs follow data, inputs high");
        wr(12'h00C, 32'h00);
        pin_chk(8'hF4, "R2 masked write clears bits 0,1 only");
        rd_chk(12'h3FC, 32'h04, "R2 input bits not written");
        rd_chk(12'h010, 32'h04, "R1 mask 0x04 read");
        rd_chk(12'h004, 32'h00, "R1 mask 0x01 read");

        // Input capture
        set_pins(8'hAA);
        rd_chk(12'h3FC, 32'hA4, "R5 inputs captured, outputs ignore pins");
        rd_chk(12'h3C0, 32'hA0, "R1 upper mask read");
        rd_chk(12'h414, 32'h00, "R7 rising ignored in falling mode");

        // Edge interrupts
        wr(12'h410, 32'hF0);
        wr(12'h40C, 32'h10);
        set_pins(8'hBA);
        rd_chk(12'h414, 32'h10, "R7 rising edge bit4");
        rd_chk(12'h418, 32'h10, "R8 masked status");
        irq_chk(1'b1, "R8 irq asserted");
        wr(12'h41C, 32'h10);
        rd_chk(12'h414, 32'h00, "R8 clear");
        irq_chk(1'b0, "R8 irq deasserted");
        wr(12'h408, 32'h40);
        set_pins(8'hFA);
        rd_chk(12'h414, 32'h40, "R7 both edges rise bit6");
        wr(12'h41C, 32'h40);
        set_pins(8'hBA);
        rd_chk(12'h414, 32'h40, "R7 both edges fall bit6");
        wr(12'h41C, 32'h40);
        set_pins(8'h3A);
        rd_chk(12'h414, 32'h80, "R7 falling edge bit7");
        wr(12'h410, 32'h00);
        rd_chk(12'h418, 32'h00, "R8 disabled bit masked");
        irq_chk(1'b0, "R8 irq masked off");
        wr(12'h410, 32'hF0);
        irq_chk(1'b1, "R8 irq re-enabled");
        wr(12'h41C, 32'h80);
        rd_chk(12'h414, 32'h00, "R8 clear bit7");

        // Level interrupts
        wr(12'h40C, 32'h30);
        wr(12'h404, 32'h20);
        rd_chk(12'h414, 32'h20, "R6 high level bit5");
        wr(12'h41C, 32'h20);
        rd_chk(12'h414, 32'h20, "R6 level re-sets after clear");
        set_pins(8'h1A);
        wr(12'h41C, 32'h20);
        rd_chk(12'h414, 32'h00, "R6 level gone, clear sticks");
        irq_chk(1'b0, "R6 irq low after level ends");

        // Lock and commit
        wr(12'h524, 32'h0F);
        rd_chk(12'h524, 32'hFF, "R10 commit frozen while locked");
        wr(12'h420, 32'hFF);
        rd_chk(12'h420, 32'hFF, "R11 all bits committed");
        wr(12'h520, 32'h0ACC_E551);
        rd_chk(12'h520, 32'h0, "R9 unlocked by key");
        wr(12'h524, 32'h0F);
        rd_chk(12'h524, 32'h0F, "R10 commit written when unlocked");
        wr(12'h420, 32'h00);
        rd_chk(12'h420, 32'hF0, "R11 uncommitted bits kept");
        wr(12'h520, 32'h1234_5678);
        rd_chk(12'h520, 32'h1, "R9 wrong key locks");
        wr(12'h524, 32'h00);
        rd_chk(12'h524, 32'h0F, "R10 relocked commit frozen");

        // Pad storage
        for (int k = 0; k < 9; k++) begin
            logic [11:0] a;
            a = (k < 8) ? 12'(12'h500 + 4 * k) : 12'h528;
            wr(a, 32'h0000_0100 | 32'((k * 37 + 5) & 8'hFF));
        end
        for (int k = 0; k < 9; k++) begin
            logic [11:0] a;
            a = (k < 8) ? 12'(12'h500 + 4 * k) : 12'h528;
            rd_chk(a, 32'((k * 37 + 5) & 8'hFF), "R12 pad storage readback");
        end

        // Identification
        for (int k = 0; k < 12; k++)
            rd_chk(12'(12'hFD0 + 4 * k), {24'h0, id_tab[k]}, "R13 id byte");

        // Undefined offsets
        rd_chk(12'h41C, 32'h0, "R14 clear reads zero");
        wr(12'h424, 32'h55);
        rd_chk(12'h424, 32'h0, "R14 unmapped reads zero");
        rd_chk(12'h600, 32'h0, "R14 unmapped high reads zero");
        rd_chk(12'h400, 32'h0F, "R14 dir untouched by stray write");
        wr(12'h414, 32'hFF);
        rd_chk(12'h414, 32'h00, "R14 raw status read-only");
        wr(12'hFE0, 32'h00);
        rd_chk(12'hFE0, 32'h61, "R14 id not writable");
        pin_chk(8'hF4, "R14 pins unchanged");

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule